// File: doc/BRIEF.md
# Attraction Memory Node Controller

This block is the per-node coherence controller of a memory system in which every node's local memory behaves as a cache and no address has a fixed home. It keeps a small fully associative array of items (address tag, coherence state, data word), serves one processor read or write at a time, and exchanges single-cycle transactions with its parent directory over a split-transaction bus.

Each item is in one of three stable states (Invalid, Shared, Exclusive) or one of three transient states (Reading, Waiting, Reading-and-Waiting). A write needs exclusivity, and it stays stalled until the directory acknowledges the erase. A write that loses a race for an item must read the item again before it erases a second time. When the array is full, a miss first evicts a victim with an out transaction. An inject offered by the directory is taken when a free slot exists, and the node then becomes the item's holder.

The processor holds `cpu_req` and its operands steady until `cpu_done` pulses. Incoming bus transactions take priority over the processor in every cycle. At most one outgoing transaction is produced per cycle, and it appears in the same cycle as its cause.

Top module: `am_node_ctrl`

## Requirements
- R1: After reset every slot is Invalid and no outgoing transaction or stall is present; the first processor read of any address emits a read (op code 1) carrying that address in the cycle of the request.
- R2: A read miss moves the item to Reading; a data transaction (op 2) for it moves it to Shared, and the held read completes in the next processor cycle with the data carried by the bus.
- R3: A write to a Shared item emits an erase (op 3) and moves the item to Waiting. The write stays stalled until an exclusive acknowledge (op 4) arrives. The item is then Exclusive, and the write completes with no further bus traffic, as do later reads of the item, which return the written value.
- R4: An incoming erase for an item in Waiting means the local write lost the race: the item moves to Reading-and-Waiting and a read is emitted in the same cycle. The data reply moves it back to Waiting and emits a new erase in the same cycle.
- R5: An incoming erase for an item held Shared or Exclusive invalidates it, so the next processor read of it emits a read.
- R6: An incoming read for an item held Shared or Exclusive is answered in the same cycle with a data transaction carrying the item's value. An Exclusive item drops to Shared, so a later write must erase again.
- R7: A miss with no Invalid slot evicts a victim with an out transaction (op 5) carrying the victim's address and data, then reads in the next cycle. The victim is the lowest-numbered Shared slot, or failing that the lowest-numbered Exclusive slot, and never a transient one. When every slot is transient, the request stalls and emits nothing.
- R8: An incoming inject (op 6) raises `inj_ack` in the same cycle when the node already holds the address or has an Invalid slot. A new address is installed as Shared with the injected data. With no free slot and no copy held, `inj_ack` stays low.
- R9: A processor request to an item in a transient state stalls and emits no transaction.
- R10: In a cycle with `bus_in_valid` high the processor request is not served: `cpu_done` stays low.
- R11: A data transaction reaching an item in Waiting stores the data but leaves the item Waiting, so the write completes only after the acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor request, held until done |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Item address |
| cpu_wdata | input | DATA_W | Write data |
| cpu_done | output | 1 | Request completes this cycle |
| cpu_stall | output | 1 | Request pending and not completing |
| cpu_rdata | output | DATA_W | Item value, valid with cpu_done |
| bus_in_valid | input | 1 | Incoming transaction present |
| bus_in_op | input | 3 | Incoming op code |
| bus_in_addr | input | ADDR_W | Incoming address |
| bus_in_data | input | DATA_W | Incoming data |
| bus_out_valid | output | 1 | Outgoing transaction present |
| bus_out_op | output | 3 | Outgoing op code |
| bus_out_addr | output | ADDR_W | Outgoing address |
| bus_out_data | output | DATA_W | Outgoing data |
| inj_ack | output | 1 | Incoming inject accepted |

## Verification
The assertions assume that the directory keeps to the protocol. It sends an exclusive acknowledge or data only for an address this node asked for, it sends an inject only for an item with no other copy, and it never answers in the same cycle as the request it answers. They also assume that the processor holds its operands steady while a request is pending. The bench acts as that directory: it replies one cycle after each outgoing transaction and starts a bus transaction from outside only on addresses and in states the protocol allows. Random accesses run over eight addresses, twice the slot count, so replacement happens often.

// File: rtl/am_pkg.sv
package am_pkg;
   typedef enum logic [2:0] {
      ST_INV = 3'd0, ST_SHD = 3'd1, ST_EXC = 3'd2,
      ST_RDG = 3'd3, ST_WTG = 3'd4, ST_RWT = 3'd5
   } item_st_t;

   typedef enum logic [2:0] {
      OP_NONE = 3'd0, OP_READ = 3'd1, OP_DATA = 3'd2, OP_ERASE = 3'd3,
      OP_EXCL = 3'd4, OP_OUT = 3'd5, OP_INJECT = 3'd6
   } bus_op_t;

   function automatic logic is_transient(item_st_t s);
      return (s == ST_RDG) || (s == ST_WTG) || (s == ST_RWT);
   endfunction
endpackage

// File: rtl/am_lookup.sv
module am_lookup #(
   parameter int SLOTS = 4,
   parameter int TAG_W = 8,
   localparam int IW = $clog2(SLOTS)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [SLOTS-1:0][TAG_W-1:0] tags,
   input  logic [SLOTS-1:0]           live,
   input  logic [TAG_W-1:0]           key,
   output logic                       hit,
   output logic [IW-1:0]              idx
);
   logic [SLOTS-1:0] match;

   for (genvar g = 0; g < SLOTS; g++) begin : g_cmp
      assign match[g] = live[g] && (tags[g] == key);
   end

   always_comb begin
      idx = '0;
      for (int i = 0; i < SLOTS; i++)
         if (match[i]) idx = IW'(i);
   end

   assign hit = |match;

   // R7: allocation only on a miss, so an address never sits in two slots
   a_r7_single_copy: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(match) <= 1);
endmodule

// File: rtl/am_victim.sv
module am_victim
   import am_pkg::*;
#(
   parameter int SLOTS = 4,
   localparam int IW = $clog2(SLOTS)
) (
   input  item_st_t [SLOTS-1:0] st,
   output logic                 found,
   output logic [IW-1:0]        idx
);
   // later loops override earlier ones: Invalid beats Shared beats Exclusive,
   // and the lowest index wins inside each class
   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int i = SLOTS - 1; i >= 0; i--)
         if (st[i] == ST_EXC) begin found = 1'b1; idx = IW'(i); end
      for (int i = SLOTS - 1; i >= 0; i--)
         if (st[i] == ST_SHD) begin found = 1'b1; idx = IW'(i); end
      for (int i = SLOTS - 1; i >= 0; i--)
         if (st[i] == ST_INV) begin found = 1'b1; idx = IW'(i); end
   end
endmodule

// File: rtl/am_node_ctrl.sv
module am_node_ctrl
   import am_pkg::*;
#(
   parameter int SLOTS  = 4,
   parameter int ADDR_W = 8,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic              cpu_done,
   output logic              cpu_stall,
   output logic [DATA_W-1:0] cpu_rdata,
   input  logic              bus_in_valid,
   input  logic [2:0]        bus_in_op,
   input  logic [ADDR_W-1:0] bus_in_addr,
   input  logic [DATA_W-1:0] bus_in_data,
   output logic              bus_out_valid,
   output logic [2:0]        bus_out_op,
   output logic [ADDR_W-1:0] bus_out_addr,
   output logic [DATA_W-1:0] bus_out_data,
   output logic              inj_ack
);
   localparam int IW = $clog2(SLOTS);

   initial begin
      assert (SLOTS >= 2 && (1 << IW) == SLOTS) else $fatal(1, "SLOTS must be a power of two >= 2");
      assert (ADDR_W >= 1 && DATA_W >= 1) else $fatal(1, "bad widths");
   end

   item_st_t [SLOTS-1:0]             st_q;
   logic     [SLOTS-1:0][ADDR_W-1:0] tag_q;
   logic     [SLOTS-1:0][DATA_W-1:0] dat_q;
   logic     [SLOTS-1:0]             live;

   for (genvar g = 0; g < SLOTS; g++) begin : g_live
      assign live[g] = (st_q[g] != ST_INV);
   end

   logic          c_hit, b_hit, v_found;
   logic [IW-1:0] c_idx, b_idx, v_idx;

   am_lookup #(.SLOTS(SLOTS), .TAG_W(ADDR_W)) u_cpu_lu (
      .clk(clk), .rst_n(rst_n), .tags(tag_q), .live(live),
      .key(cpu_addr), .hit(c_hit), .idx(c_idx));

   am_lookup #(.SLOTS(SLOTS), .TAG_W(ADDR_W)) u_bus_lu (
      .clk(clk), .rst_n(rst_n), .tags(tag_q), .live(live),
      .key(bus_in_addr), .hit(b_hit), .idx(b_idx));

   am_victim #(.SLOTS(SLOTS)) u_victim (
      .st(st_q), .found(v_found), .idx(v_idx));

   logic              upd, upd_tw, upd_dw;
   logic [IW-1:0]     upd_idx;
   item_st_t          upd_st;
   logic [ADDR_W-1:0] upd_tag;
   logic [DATA_W-1:0] upd_dat;

   always_comb begin
      upd = 1'b0; upd_tw = 1'b0; upd_dw = 1'b0; upd_idx = '0;
      upd_st = ST_INV; upd_tag = '0; upd_dat = '0;
      bus_out_valid = 1'b0; bus_out_op = OP_NONE;
      bus_out_addr = '0; bus_out_data = '0;
      cpu_done = 1'b0; cpu_rdata = '0; inj_ack = 1'b0;
      if (bus_in_valid) begin
         case (bus_in_op)
            OP_DATA: if (b_hit) begin
               upd_idx = b_idx; upd_dat = bus_in_data;
               case (st_q[b_idx])
                  ST_RDG: begin upd = 1'b1; upd_dw = 1'b1; upd_st = ST_SHD; end
                  ST_WTG: begin upd = 1'b1; upd_dw = 1'b1; upd_st = ST_WTG; end
                  ST_RWT: begin
                     upd = 1'b1; upd_dw = 1'b1; upd_st = ST_WTG;
                     bus_out_valid = 1'b1; bus_out_op = OP_ERASE;
                     bus_out_addr = bus_in_addr;
                  end
                  default: ;
               endcase
            end
            OP_EXCL: if (b_hit && st_q[b_idx] == ST_WTG) begin
               upd = 1'b1; upd_idx = b_idx; upd_st = ST_EXC;
            end
            OP_ERASE: if (b_hit) begin
               upd_idx = b_idx;
               case (st_q[b_idx])
                  ST_SHD, ST_EXC: begin upd = 1'b1; upd_st = ST_INV; end
                  ST_WTG: begin
                     upd = 1'b1; upd_st = ST_RWT;
                     bus_out_valid = 1'b1; bus_out_op = OP_READ;
                     bus_out_addr = bus_in_addr;
                  end
                  default: ;
               endcase
            end
            OP_READ: if (b_hit && (st_q[b_idx] == ST_SHD || st_q[b_idx] == ST_EXC)) begin
               bus_out_valid = 1'b1; bus_out_op = OP_DATA;
               bus_out_addr = bus_in_addr; bus_out_data = dat_q[b_idx];
               upd = (st_q[b_idx] == ST_EXC); upd_idx = b_idx; upd_st = ST_SHD;
            end
            OP_INJECT: begin
               if (b_hit) inj_ack = 1'b1;
               else if (v_found && st_q[v_idx] == ST_INV) begin
                  inj_ack = 1'b1; upd = 1'b1; upd_tw = 1'b1; upd_dw = 1'b1;
                  upd_idx = v_idx; upd_st = ST_SHD;
                  upd_tag = bus_in_addr; upd_dat = bus_in_data;
               end
            end
            default: ;
         endcase
      end else if (cpu_req) begin
         if (c_hit) begin
            upd_idx = c_idx;
            case (st_q[c_idx])
               ST_SHD: if (!cpu_we) begin
                  cpu_done = 1'b1; cpu_rdata = dat_q[c_idx];
               end else begin
                  upd = 1'b1; upd_st = ST_WTG;
                  bus_out_valid = 1'b1; bus_out_op = OP_ERASE; bus_out_addr = cpu_addr;
               end
               ST_EXC: begin
                  cpu_done = 1'b1;
                  cpu_rdata = cpu_we ? cpu_wdata : dat_q[c_idx];
                  upd = cpu_we; upd_dw = 1'b1; upd_st = ST_EXC; upd_dat = cpu_wdata;
               end
               default: ;
            endcase
         end else if (v_found) begin
            upd = 1'b1; upd_idx = v_idx;
            if (st_q[v_idx] == ST_INV) begin
               upd_tw = 1'b1; upd_tag = cpu_addr; upd_st = ST_RDG;
               bus_out_valid = 1'b1; bus_out_op = OP_READ; bus_out_addr = cpu_addr;
            end else begin
               upd_st = ST_INV;
               bus_out_valid = 1'b1; bus_out_op = OP_OUT;
               bus_out_addr = tag_q[v_idx]; bus_out_data = dat_q[v_idx];
            end
         end
      end
   end

   assign cpu_stall = cpu_req && !cpu_done;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < SLOTS; i++) begin
            st_q[i]  <= ST_INV;
            tag_q[i] <= '0;
            dat_q[i] <= '0;
         end
      end else if (upd) begin
         st_q[upd_idx] <= upd_st;
         if (upd_tw) tag_q[upd_idx] <= upd_tag;
         if (upd_dw) dat_q[upd_idx] <= upd_dat;
      end
   end

   // R10: the processor is never completed while the bus has priority
   a_r10_bus_first: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_done |-> !bus_in_valid);

   // R7: the chosen victim is never in a transient state
   a_r7_victim_stable: assert property (@(posedge clk) disable iff (!rst_n)
      v_found |-> !is_transient(st_q[v_idx]));

   // R8: acceptance is only signalled for an inject
   a_r8_ack_on_inject: assert property (@(posedge clk) disable iff (!rst_n)
      inj_ack |-> (bus_in_valid && bus_in_op == OP_INJECT));

   for (genvar g = 0; g < SLOTS; g++) begin : g_chk
      // R3: Waiting becomes Exclusive only after an acknowledge
      a_r3_excl_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
         (st_q[g] == ST_EXC && $past(st_q[g]) == ST_WTG)
            |-> $past(bus_in_valid && bus_in_op == OP_EXCL));
      // R2: Reading becomes Shared only after data
      a_r2_shared_after_data: assert property (@(posedge clk) disable iff (!rst_n)
         (st_q[g] == ST_SHD && $past(st_q[g]) == ST_RDG)
            |-> $past(bus_in_valid && bus_in_op == OP_DATA));
      // R4: Reading-and-Waiting is left only on data
      a_r4_rw_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(st_q[g]) == ST_RWT && st_q[g] != ST_RWT)
            |-> $past(bus_in_valid && bus_in_op == OP_DATA));
   end
endmodule

// File: tb/am_node_ctrl_bench.sv
module am_node_ctrl_bench;
   localparam int AW = 8;
   localparam int DW = 16;
   localparam logic [2:0] RD = 3'd1, DT = 3'd2, ER = 3'd3, EX = 3'd4, OT = 3'd5, IJ = 3'd6;

   logic clk = 1'b0, rst_n = 1'b0;
   logic cpu_req = 0, cpu_we = 0;
   logic [AW-1:0] cpu_addr = '0;
   logic [DW-1:0] cpu_wdata = '0;
   logic cpu_done, cpu_stall, bus_out_valid, inj_ack;
   logic [DW-1:0] cpu_rdata, bus_out_data;
   logic bus_in_valid = 0;
   logic [2:0] bus_in_op = '0, bus_out_op;
   logic [AW-1:0] bus_in_addr = '0, bus_out_addr;
   logic [DW-1:0] bus_in_data = '0;

   always #10 clk = ~clk;

   am_node_ctrl #(.SLOTS(4), .ADDR_W(AW), .DATA_W(DW)) u_am_node_ctrl (
      .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
      .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_done(cpu_done),
      .cpu_stall(cpu_stall), .cpu_rdata(cpu_rdata), .bus_in_valid(bus_in_valid),
      .bus_in_op(bus_in_op), .bus_in_addr(bus_in_addr), .bus_in_data(bus_in_data),
      .bus_out_valid(bus_out_valid), .bus_out_op(bus_out_op),
      .bus_out_addr(bus_out_addr), .bus_out_data(bus_out_data), .inj_ack(inj_ack));

   int n_chk = 0, n_fail = 0;
   logic [DW-1:0] dir_mem [256];
   logic [DW-1:0] exp_mem [256];

   task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", r, act, exp);
      end
   endtask

   // drive one cycle at the falling edge, sample the outputs 5 ns later
   task automatic cyc(input logic rq, input logic we, input logic [AW-1:0] ca,
                      input logic [DW-1:0] cd, input logic bv, input logic [2:0] op,
                      input logic [AW-1:0] ba, input logic [DW-1:0] bd);
      @(negedge clk);
      cpu_req = rq; cpu_we = we; cpu_addr = ca; cpu_wdata = cd;
      bus_in_valid = bv; bus_in_op = op; bus_in_addr = ba; bus_in_data = bd;
      #5;
   endtask

   function automatic logic [DW-1:0] init_val(input int a);
      return DW'(a * 37 + 11);
   endfunction

   // full access with the bench acting as the parent directory
   task automatic access(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                         output logic [DW-1:0] q, output logic ok);
      logic pv = 0; logic [2:0] pop = '0; logic [AW-1:0] pa = '0; logic [DW-1:0] pd = '0;
      ok = 0; q = '0;
      for (int k = 0; k < 40; k++) begin
         cyc(1, we, a, d, pv, pop, pa, pd);
         pv = 0;
         if (bus_out_valid) begin
            case (bus_out_op)
               RD: begin pv = 1; pop = DT; pa = bus_out_addr; pd = dir_mem[bus_out_addr]; end
               ER: begin pv = 1; pop = EX; pa = bus_out_addr; pd = '0; end
               OT: dir_mem[bus_out_addr] = bus_out_data;
               default: ;
            endcase
         end
         if (cpu_done) begin q = cpu_rdata; ok = 1; break; end
      end
      cyc(0, 0, 0, 0, 0, 0, 0, 0);
   endtask

   task automatic finish_run();
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      #(20 * 150000);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic [DW-1:0] q; logic ok;
      void'($urandom(32'h0000_5EED));
      for (int i = 0; i < 256; i++) begin dir_mem[i] = init_val(i); exp_mem[i] = init_val(i); end
      repeat (3) @(negedge clk);
      rst_n = 1;
      #5;
      chk("R1 reset out valid", bus_out_valid, 0);
      chk("R1 reset stall", cpu_stall, 0);

      cyc(1, 0, 8'h10, 0, 0, 0, 0, 0);
      chk("R1 first read op", {bus_out_valid, bus_out_op}, {1'b1, RD});
      chk("R1 first read addr", bus_out_addr, 8'h10);
      chk("R1 no done", cpu_done, 0);
      cyc(1, 0, 8'h10, 0, 0, 0, 0, 0);
      chk("R9 reading stalls quietly", {bus_out_valid, cpu_done, cpu_stall}, 3'b001);
      cyc(1, 0, 8'h10, 0, 1, DT, 8'h10, 16'hABCD);
      chk("R10 no done while bus busy", cpu_done, 0);
      cyc(1, 0, 8'h10, 0, 0, 0, 0, 0);
      chk("R2 read done", cpu_done, 1);
      chk("R2 read data", cpu_rdata, 16'hABCD);

      cyc(1, 1, 8'h10, 16'h1111, 0, 0, 0, 0);
      chk("R3 erase on shared write", {bus_out_valid, bus_out_op, bus_out_addr}, {1'b1, ER, 8'h10});
      chk("R3 write stalled", cpu_done, 0);
      cyc(1, 1, 8'h10, 16'h1111, 1, DT, 8'h10, 16'h2222);
      chk("R11 data to waiting no out", bus_out_valid, 0);
      cyc(1, 1, 8'h10, 16'h1111, 0, 0, 0, 0);
      chk("R11 still waiting", {cpu_done, bus_out_valid}, 2'b00);
      cyc(1, 1, 8'h10, 16'h1111, 1, EX, 8'h10, 0);
      cyc(1, 1, 8'h10, 16'h1111, 0, 0, 0, 0);
      chk("R3 write done after ack", {cpu_done, bus_out_valid}, 2'b10);
      cyc(1, 0, 8'h10, 0, 0, 0, 0, 0);
      chk("R3 exclusive read hit", {cpu_done, bus_out_valid, cpu_rdata}, {2'b10, 16'h1111});

      cyc(0, 0, 0, 0, 1, RD, 8'h10, 0);
      chk("R6 answer read", {bus_out_valid, bus_out_op, bus_out_addr, bus_out_data},
          {1'b1, DT, 8'h10, 16'h1111});
      cyc(1, 1, 8'h10, 16'h3333, 0, 0, 0, 0);
      chk("R6 downgraded needs erase", {bus_out_valid, bus_out_op}, {1'b1, ER});
      cyc(1, 1, 8'h10, 16'h3333, 1, ER, 8'h10, 0);
      chk("R4 lost race rereads", {bus_out_valid, bus_out_op, bus_out_addr}, {1'b1, RD, 8'h10});
      cyc(1, 1, 8'h10, 16'h3333, 0, 0, 0, 0);
      chk("R9 rw stalls quietly", {bus_out_valid, cpu_done}, 2'b00);
      cyc(1, 1, 8'h10, 16'h3333, 1, DT, 8'h10, 16'h4444);
      chk("R4 erase again after data", {bus_out_valid, bus_out_op}, {1'b1, ER});
      cyc(1, 1, 8'h10, 16'h3333, 1, EX, 8'h10, 0);
      cyc(1, 1, 8'h10, 16'h3333, 0, 0, 0, 0);
      chk("R4 write completes", cpu_done, 1);

      cyc(0, 0, 0, 0, 1, ER, 8'h10, 0);
      chk("R5 erase of exclusive silent", bus_out_valid, 0);
      cyc(1, 0, 8'h10, 0, 0, 0, 0, 0);
      chk("R5 invalidated read misses", {bus_out_valid, bus_out_op}, {1'b1, RD});
      cyc(1, 0, 8'h10, 0, 1, DT, 8'h10, 16'h5555);
      cyc(1, 0, 8'h10, 0, 0, 0, 0, 0);
      chk("R2 refetched data", cpu_rdata, 16'h5555);
      cyc(0, 0, 0, 0, 0, 0, 0, 0);

      access(0, 8'h20, 0, q, ok);
      access(0, 8'h30, 0, q, ok);
      access(0, 8'h40, 0, q, ok);
      cyc(1, 0, 8'h50, 0, 0, 0, 0, 0);
      chk("R7 evict lowest shared", {bus_out_valid, bus_out_op, bus_out_addr, bus_out_data},
          {1'b1, OT, 8'h10, 16'h5555});
      cyc(1, 0, 8'h50, 0, 0, 0, 0, 0);
      chk("R7 read after out", {bus_out_op, bus_out_addr}, {RD, 8'h50});
      cyc(1, 0, 8'h50, 0, 1, DT, 8'h50, 16'h5050);
      cyc(1, 0, 8'h50, 0, 0, 0, 0, 0);
      access(1, 8'h20, 16'h2020, q, ok);
      chk("R3 write via access", ok, 1);
      cyc(1, 0, 8'h60, 0, 0, 0, 0, 0);
      chk("R7 evict shared slot0", {bus_out_op, bus_out_addr}, {OT, 8'h50});
      cyc(1, 0, 8'h60, 0, 0, 0, 0, 0);
      cyc(1, 0, 8'h70, 0, 0, 0, 0, 0);
      chk("R7 skip transient and exclusive", {bus_out_op, bus_out_addr}, {OT, 8'h30});
      cyc(1, 0, 8'h70, 0, 0, 0, 0, 0);
      cyc(1, 0, 8'h80, 0, 0, 0, 0, 0);
      cyc(1, 0, 8'h80, 0, 0, 0, 0, 0);
      cyc(1, 0, 8'h90, 0, 0, 0, 0, 0);
      chk("R7 exclusive evicted last", {bus_out_op, bus_out_addr, bus_out_data}, {OT, 8'h20, 16'h2020});
      cyc(1, 0, 8'h90, 0, 0, 0, 0, 0);
      chk("R7 read after exclusive out", {bus_out_op, bus_out_addr}, {RD, 8'h90});
      cyc(1, 0, 8'hA0, 0, 0, 0, 0, 0);
      chk("R7 all transient stall", {bus_out_valid, cpu_done, cpu_stall}, 3'b001);
      cyc(0, 0, 0, 0, 1, IJ, 8'hB0, 16'hBEEF);
      chk("R8 inject refused when full", inj_ack, 0);
      cyc(0, 0, 0, 0, 1, DT, 8'h60, 16'h6060);
      cyc(0, 0, 0, 0, 1, ER, 8'h60, 0);
      cyc(0, 0, 0, 0, 1, IJ, 8'hB0, 16'hBEEF);
      chk("R8 inject accepted", inj_ack, 1);
      cyc(0, 0, 0, 0, 1, DT, 8'h70, dir_mem[8'h70]);
      cyc(0, 0, 0, 0, 1, DT, 8'h80, dir_mem[8'h80]);
      cyc(0, 0, 0, 0, 1, DT, 8'h90, dir_mem[8'h90]);
      cyc(1, 0, 8'hB0, 0, 0, 0, 0, 0);
      chk("R8 injected item hits", {cpu_done, bus_out_valid, cpu_rdata}, {2'b10, 16'hBEEF});
      cyc(0, 0, 0, 0, 0, 0, 0, 0);

      for (int n = 0; n < 120; n++) begin
         logic [AW-1:0] a; logic we; logic [DW-1:0] d;
         a = 8'hC0 + AW'($urandom % 8);
         if ($urandom % 5 == 0) begin
            cyc(0, 0, 0, 0, 1, RD, a, 0);
            if (bus_out_valid)
               chk("R6 random answer value", {bus_out_op, bus_out_data}, {DT, exp_mem[a]});
            continue;
         end
         we = 1'($urandom % 2);
         d  = DW'($urandom);
         access(we, a, d, q, ok);
         chk(we ? "R3 random write completes" : "R2 random read completes", ok, 1);
         if (we) exp_mem[a] = d;
         else chk("R2 random read value", q, exp_mem[a]);
      end
      finish_run();
   end
endmodule